// File: doc/BRIEF.md
# Sixteen-bit reloading timer with prescaler and two overflow flags

This block is a 16-bit timer/counter for a microcontroller peripheral set. Each count event comes from one of two sources. The first is a one-cycle internal tick enable. The second is a falling edge on an external pin, which is synchronised into the clock domain first. Events pass through a divider with ratio 1, 2, 4 or 8 before they step the counter.

The counter runs up or down and reloads automatically from a 16-bit reload register. It keeps two sticky flags: one for a carry or borrow out of the low byte, and one for the full 16-bit wrap. The full-wrap flag always raises the low-byte flag as well. A single interrupt line is driven from whichever of the flags software enables.

Software reaches every register through a byte-wide port. Writes take effect on the clock edge. Reads are combinational from `rd_addr`.

Top module: `tmr16_dualflag`

## Requirements
- R1: After reset, the count, reload, control and select registers read 0, both flags are clear and `irq` is 0.
- R2: The register map uses these addresses. Address 0 is the count low byte and address 1 is the count high byte. Address 2 is the reload low byte and address 3 is the reload high byte. Address 4 is control: bit0 run, bit1 external source, bit2 count down, bit4 low-byte flag, bit5 wrap flag. Address 5 is select: bits1:0 divide code, bit4 wrap-flag interrupt enable, bit5 low-byte-flag interrupt enable. A software write to a count byte takes priority over a count step in the same cycle.
- R3: While run is 0, no input changes the count.
- R4: With the internal source, run set and divide code 0, every cycle with `tick_in` high adds one to the count, and the count changes on the edge that samples the tick.
- R5: Divide codes 0, 1, 2 and 3 step the counter once per 1, 2, 4 and 8 source events. The divider restarts from zero whenever run is 0.
- R6: With the external source, the counter counts 1-to-0 transitions of `ext_pin` after a two-stage synchroniser. Rising edges and `tick_in` are ignored.
- R7: Counting up, a step from a count whose low byte is 0xFF sets the low-byte flag. If the whole count is not 0xFFFF, the wrap flag is left unchanged.
- R8: Counting up, a step from 0xFFFF loads the reload value and sets both the wrap flag and the low-byte flag.
- R9: Counting down, a step from a count equal to the reload value loads 0xFFFF and sets both flags. Any other step decrements the count, and a step from a low byte of 0x00 sets the low-byte flag.
- R10: A flag clears only when a control write puts 0 in its bit. Writing 1 leaves the flag as it was.
- R11: `irq` is high exactly when (wrap flag and select bit4) or (low-byte flag and select bit5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Internal count tick enable |
| ext_pin | input | 1 | External count input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks the divider through every code. It includes a run of seven events at ratio 8, where a divider that fires early or never clears would show a nonzero count. Wrap cases are checked at 0x00FF and 0xFFFF counting up, and at the reload value counting down. A design that forgets to raise the low-byte flag on a wrap, reloads on the wrong count, or decrements past the reload value gives a wrong count or wrong flags there.

Separate tests check three more behaviours. External counting with `tick_in` held high catches source mixing and counting on rising edges. Writing 1 to a flag must not clear it. A count write in the same cycle as a tick must win, or the count shows a stray increment.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int SEL_W  = 2;
  localparam int PRE_W  = (1 << SEL_W) - 1;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_SEL    = 3'd5;

  // Last divider count before a step for a given divide code (ratio - 1).
  function automatic logic [PRE_W-1:0] presc_last(input logic [SEL_W-1:0] code);
    presc_last = PRE_W'((1 << code) - 1);
  endfunction

  // Carry out of the low byte when stepping up.
  function automatic logic low_carry_up(input logic [CNT_W-1:0] c);
    low_carry_up = &c[BYTE_W-1:0];
  endfunction

  // Borrow out of the low byte when stepping down.
  function automatic logic low_borrow_down(input logic [CNT_W-1:0] c);
    low_borrow_down = ~|c[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/tmr16_src.sv
module tmr16_src (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pin,
  input  logic tick_in,
  input  logic ext_sel,
  output logic src_evt,
  output logic ext_fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign ext_fall = s3 & ~s2;
  assign src_evt  = ext_sel ? ext_fall : tick_in;

  // R6: a falling edge cannot be seen on two cycles in a row
  assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> !ext_fall);
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_evt,
  input  logic [SEL_W-1:0] code,
  output logic             step
);
  logic [PRE_W-1:0] pre_cnt;
  logic             hit;

  assign hit  = (pre_cnt >= presc_last(code));
  assign step = run & src_evt & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_cnt <= '0;
    else if (!run)          pre_cnt <= '0;
    else if (src_evt & hit) pre_cnt <= '0;
    else if (src_evt)       pre_cnt <= pre_cnt + 1'b1;
  end

  // R5: a step needs a live source event while running
  assert_step_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (run && src_evt));
  // R5: the divider restarts while stopped
  assert_divider_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_cnt == '0));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              down,
  input  logic [CNT_W-1:0]  reload,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [CNT_W-1:0]  count,
  output logic              lo_evt,
  output logic              hi_evt
);
  logic [CNT_W-1:0] nxt;
  logic             live;

  assign live = step & ~wr_lo & ~wr_hi;

  always_comb begin
    nxt    = count;
    lo_evt = 1'b0;
    hi_evt = 1'b0;
    if (live) begin
      if (down) begin
        if (count == reload) begin
          nxt    = '1;
          hi_evt = 1'b1;
        end else begin
          nxt    = count - 1'b1;
          lo_evt = low_borrow_down(count);
        end
      end else begin
        if (&count) begin
          nxt    = reload;
          hi_evt = 1'b1;
        end else begin
          nxt    = count + 1'b1;
        end
        lo_evt = low_carry_up(count);
      end
    end
    if (wr_lo) nxt[BYTE_W-1:0]     = wr_byte;
    if (wr_hi) nxt[CNT_W-1:BYTE_W] = wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  // R8: up wrap loads the reload value
  assert_up_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down && (&count) && !wr_lo && !wr_hi) |=> (count == $past(reload)));
  // R9: down count at reload value goes to all ones
  assert_down_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && down && (count == reload) && !wr_lo && !wr_hi) |=> (&count));
  // R3: without step or write the count holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_lo && !wr_hi) |=> $stable(count));
endmodule

// File: rtl/tmr16_dualflag.sv
module tmr16_dualflag
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              ext_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq
);
  logic [CNT_W-1:0] reload, count;
  logic             run, ext_sel, down, lo_flag, hi_flag;
  logic [SEL_W-1:0] div_code;
  logic             ie_hi, ie_lo;
  logic             src_evt, ext_fall, step, lo_evt, hi_evt;
  logic             ctl_wr, sel_wr, wr_cnt_lo, wr_cnt_hi;

  assign ctl_wr    = wr_en && (wr_addr == A_CTRL);
  assign sel_wr    = wr_en && (wr_addr == A_SEL);
  assign wr_cnt_lo = wr_en && (wr_addr == A_CNT_LO);
  assign wr_cnt_hi = wr_en && (wr_addr == A_CNT_HI);

  tmr16_src u_src (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tick_in(tick_in),
    .ext_sel(ext_sel), .src_evt(src_evt), .ext_fall(ext_fall)
  );

  tmr16_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .src_evt(src_evt),
    .code(div_code), .step(step)
  );

  tmr16_core u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .down(down), .reload(reload),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wr_byte(wr_data),
    .count(count), .lo_evt(lo_evt), .hi_evt(hi_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload   <= '0;
      run      <= 1'b0;
      ext_sel  <= 1'b0;
      down     <= 1'b0;
      div_code <= '0;
      ie_hi    <= 1'b0;
      ie_lo    <= 1'b0;
      lo_flag  <= 1'b0;
      hi_flag  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_RLD_LO) reload[BYTE_W-1:0]     <= wr_data;
      if (wr_en && wr_addr == A_RLD_HI) reload[CNT_W-1:BYTE_W] <= wr_data;
      if (ctl_wr) begin
        run     <= wr_data[0];
        ext_sel <= wr_data[1];
        down    <= wr_data[2];
      end
      if (sel_wr) begin
        div_code <= wr_data[SEL_W-1:0];
        ie_hi    <= wr_data[4];
        ie_lo    <= wr_data[5];
      end
      lo_flag <= (lo_flag & ~(ctl_wr & ~wr_data[4])) | lo_evt | hi_evt;
      hi_flag <= (hi_flag & ~(ctl_wr & ~wr_data[5])) | hi_evt;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CNT_LO: rd_data = count[BYTE_W-1:0];
      A_CNT_HI: rd_data = count[CNT_W-1:BYTE_W];
      A_RLD_LO: rd_data = reload[BYTE_W-1:0];
      A_RLD_HI: rd_data = reload[CNT_W-1:BYTE_W];
      A_CTRL:   rd_data = {2'b00, hi_flag, lo_flag, 1'b0, down, ext_sel, run};
      A_SEL:    rd_data = {2'b00, ie_lo, ie_hi, {(4-SEL_W){1'b0}}, div_code};
      default:  rd_data = '0;
    endcase
  end

  assign irq = (hi_flag & ie_hi) | (lo_flag & ie_lo);

  // R8: a wrap always leaves both flags set
  assert_lo_follows_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_evt |=> (lo_flag && hi_flag));
  // R10: flags stay set without a control write
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_flag && !ctl_wr) |=> lo_flag);
  // R3: stopped timer never steps
  assert_no_step_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step);
  // R11: no interrupt without an enabled flag
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((hi_flag && ie_hi) || (lo_flag && ie_lo)));
endmodule

// File: tb/tmr16_dualflag_tb.sv
module tmr16_dualflag_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       ext_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr16_dualflag dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ext_pin(ext_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // divide code, tick count, expected count starting from zero (R5)
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'd5,  16'd5},
    {2'd1, 8'd5,  16'd2},
    {2'd1, 8'd6,  16'd3},
    {2'd2, 8'd9,  16'd2},
    {2'd2, 8'd4,  16'd1},
    {2'd3, 8'd16, 16'd2},
    {2'd3, 8'd7,  16'd0},
    {2'd0, 8'd1,  16'd1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(a, lo); rd8(a + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd16(3'd0, v); chk("R1 count", v, 16'h0000);
    rd16(3'd2, v); chk("R1 reload", v, 16'h0000);
    rd8(3'd4, b);  chk("R1 ctrl", {8'h0, b}, 16'h0000);
    rd8(3'd5, b);  chk("R1 sel", {8'h0, b}, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0000);

    // R4 / R5 table walk
    for (int k = 0; k < NV; k++) begin
      wr(3'd4, 8'h00);
      set_cnt(16'h0000);
      wr(3'd5, {6'b0, VEC[k][25:24]});
      wr(3'd4, 8'h01);
      ticks(int'(VEC[k][23:16]));
      wr(3'd4, 8'h00);
      rd16(3'd0, v);
      chk($sformatf("R5 R4 vector %0d", k), v, VEC[k][15:0]);
    end

    // R3 stopped counter ignores ticks
    wr(3'd5, 8'h00);
    set_cnt(16'h0042);
    ticks(5);
    rd16(3'd0, v); chk("R3 stopped", v, 16'h0042);

    // R2 reload register read back
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    rd16(3'd2, v); chk("R2 reload readback", v, 16'h1234);

    // R7 low-byte carry only
    set_cnt(16'h00FF);
    wr(3'd4, 8'h01);
    ticks(1);
    rd16(3'd0, v); chk("R7 count", v, 16'h0100);
    rd8(3'd4, b);  chk("R7 flags", {14'h0, b[5:4]}, 16'h0001);

    // R11 irq select with only the low-byte flag set
    wr(3'd5, 8'h10); chk("R11 hi-only enable", {15'h0, irq}, 16'h0000);
    wr(3'd5, 8'h20); chk("R11 lo enable", {15'h0, irq}, 16'h0001);
    wr(3'd5, 8'h30); chk("R11 both enables", {15'h0, irq}, 16'h0001);
    wr(3'd5, 8'h00); chk("R11 none", {15'h0, irq}, 16'h0000);

    // R10 writing 1 keeps the flag, writing 0 clears it
    wr(3'd4, 8'h11);
    rd8(3'd4, b); chk("R10 write one keeps", {14'h0, b[5:4]}, 16'h0001);
    wr(3'd4, 8'h01);
    rd8(3'd4, b); chk("R10 write zero clears", {14'h0, b[5:4]}, 16'h0000);

    // R8 up wrap to reload 0x1234
    set_cnt(16'hFFFE);
    ticks(1);
    rd16(3'd0, v); chk("R8 pre-wrap", v, 16'hFFFF);
    rd8(3'd4, b);  chk("R8 no flag before wrap", {14'h0, b[5:4]}, 16'h0000);
    ticks(1);
    rd16(3'd0, v); chk("R8 reloaded", v, 16'h1234);
    rd8(3'd4, b);  chk("R8 both flags", {14'h0, b[5:4]}, 16'h0003);
    wr(3'd5, 8'h10); chk("R11 wrap irq", {15'h0, irq}, 16'h0001);
    wr(3'd5, 8'h00);

    // R9 down: low-byte borrow
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h05); wr(3'd3, 8'h00);
    set_cnt(16'h0200);
    wr(3'd4, 8'h05);
    ticks(1);
    rd16(3'd0, v); chk("R9 borrow count", v, 16'h01FF);
    rd8(3'd4, b);  chk("R9 borrow flags", {14'h0, b[5:4]}, 16'h0001);

    // R9 down: reaching reload value loads all ones
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h01);
    set_cnt(16'h0101);
    wr(3'd4, 8'h05);
    ticks(1);
    rd16(3'd0, v); chk("R9 at reload", v, 16'h0100);
    rd8(3'd4, b);  chk("R9 no wrap yet", {14'h0, b[5:4]}, 16'h0000);
    ticks(1);
    rd16(3'd0, v); chk("R9 wrap count", v, 16'hFFFF);
    rd8(3'd4, b);  chk("R9 wrap flags", {14'h0, b[5:4]}, 16'h0003);

    // R2 count write wins over a same-cycle tick
    wr(3'd4, 8'h01);
    set_cnt(16'h0005);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h40; tick_in = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_in = 1'b0;
    rd16(3'd0, v); chk("R2 write priority", v, 16'h4005);

    // R6 external falling edges with tick_in held high
    wr(3'd4, 8'h00);
    set_cnt(16'h0000);
    tick_in = 1'b1;
    wr(3'd4, 8'h03);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); ext_pin = 1'b1;
      repeat (3) @(negedge clk);
      ext_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    wr(3'd4, 8'h00);
    tick_in = 1'b0;
    rd16(3'd0, v); chk("R6 external edges", v, 16'h0004);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule